// File: doc/BRIEF.md
# Seven-Line LED-Dimming GPIO Port

This block is a small general-purpose I/O port of seven lines for a touch-controller chip. Each line is either an input, whose level is brought into the clock domain and read back by the host, or an output that drives an LED. The level an output shows comes from one of two sources: the host-written data bit for that line, or the live detect flag of the touch key linked to it. A touched key can therefore light its own LED with no host involvement.

The chosen source level then passes through two more stages. A shared pulse-width gate lets the active state through only for a programmable share of each 256-cycle period. A per-line polarity bit then picks whether "active" is a high or a low pad level. The host reaches the port through a plain address/data register port with a write strobe and a combinational read path. A strap input forces every line to be an output, for builds that run without a host.

Top module: `gpio_pwm`

## Requirements
- R1: After reset every configuration register (direction, polarity, key link, host data, level) reads 0, all output enables are low and every pad output is high (inactive for active low).
- R2: Register addresses: 0 direction, 1 polarity, 2 key link, 3 host data, 4 PWM level, 5 input status (read only). A write to addresses 0 to 4 reads back at the same address. Addresses 6 and 7 read 0, and a write to them changes no register.
- R3: Output enable bit i follows direction bit i (1 = output, 0 = input). While the force input is high all seven enables are 1 (0x7F), and the stored direction value is unchanged.
- R4: For lines 0 to 5, key link bit i = 1 makes the line's source level key detect i; 0 makes it host data bit i.
- R5: Line 6 has no key. Its key-link bit is not stored and reads 0. Line 6 always follows host data bit 6.
- R6: Polarity bit i = 1 makes the line active high; 0 makes it active low.
- R7: A free-running 8-bit counter gates the active state. Over any 256 consecutive cycles, a line whose source is 1 is active for exactly `level` cycles: 0 gives never, 255 gives 255 of 256.
- R8: A line whose source level is 0 stays at its inactive pad level on every cycle, whatever the PWM level.
- R9: Input status bit i shows pad input i through a two-flop synchronizer. A change is visible after the second clock edge and not after the first. Bits of lines that are currently outputs read 0.
- R10: Pad outputs are registered: a change on a key detect reaches the pad one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| keyDetect | input | 6 | Detect flags from the touch keys |
| forceOutputs | input | 1 | Strap: make every line an output |
| padIn | input | 7 | Pad input levels (asynchronous) |
| padOut | output | 7 | Pad output levels |
| padOe | output | 7 | Pad output enables |

## Verification
The bench builds the block with its default parameters: seven lines, six keys, an 8-bit PWM and 8-bit data. This makes the line without a key (line 6) and the full 256-cycle PWM period part of every run. Because a whole period is only 256 cycles, the bench can count active cycles over exact windows and compare them with the level for several values, including both ends. That check does not depend on the counter's phase.

// File: rtl/gpio_pwm_pkg.sv
package gpio_pwm_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DIR   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_POL   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LINK  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HOST  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd5;

  typedef enum logic [2:0] {
    SEL_DIR, SEL_POL, SEL_LINK, SEL_HOST, SEL_LEVEL, SEL_STAT, SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic   dirWr;
    logic   polWr;
    logic   linkWr;
    logic   hostWr;
    logic   levelWr;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_pwm_ctrl.sv
module gpio_pwm_ctrl
  import gpio_pwm_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);

  // Address decode into write strobes and a read selector.
  always_comb begin
    strobe       = '0;
    strobe.rdSel = SEL_NONE;
    case (regAddr)
      ADDR_DIR: begin
        strobe.dirWr = regWrEn;
        strobe.rdSel = SEL_DIR;
      end
      ADDR_POL: begin
        strobe.polWr = regWrEn;
        strobe.rdSel = SEL_POL;
      end
      ADDR_LINK: begin
        strobe.linkWr = regWrEn;
        strobe.rdSel  = SEL_LINK;
      end
      ADDR_HOST: begin
        strobe.hostWr = regWrEn;
        strobe.rdSel  = SEL_HOST;
      end
      ADDR_LEVEL: begin
        strobe.levelWr = regWrEn;
        strobe.rdSel   = SEL_LEVEL;
      end
      ADDR_STAT: begin
        strobe.rdSel = SEL_STAT;
      end
      default: begin
        strobe.rdSel = SEL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/gpio_pwm_sync.sv
module gpio_pwm_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/gpio_pwm_dp.sv
module gpio_pwm_dp
  import gpio_pwm_pkg::*;
#(
  parameter int NUM_LINES = 7,
  parameter int NUM_KEYS  = 6,
  parameter int PWM_W     = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_KEYS-1:0]  keyDetect,
  input  logic                 forceOutputs,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe,
  output logic [DATA_W-1:0]    rdData
);

  localparam int LINK_W = (NUM_KEYS < NUM_LINES) ? NUM_KEYS : NUM_LINES;

  logic [NUM_LINES-1:0] dirReg, polReg, hostReg;
  logic [LINK_W-1:0]    linkReg;
  logic [PWM_W-1:0]     levelReg;
  logic [PWM_W-1:0]     pwmCnt;
  logic [NUM_LINES-1:0] effDir, srcLvl, activeLvl, syncIn, inStatus;
  logic                 pwmOn;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '0;
      polReg   <= '0;
      hostReg  <= '0;
      linkReg  <= '0;
      levelReg <= '0;
    end else begin
      if (strobe.dirWr)   dirReg   <= wrData[NUM_LINES-1:0];
      if (strobe.polWr)   polReg   <= wrData[NUM_LINES-1:0];
      if (strobe.hostWr)  hostReg  <= wrData[NUM_LINES-1:0];
      if (strobe.linkWr)  linkReg  <= wrData[LINK_W-1:0];
      if (strobe.levelWr) levelReg <= wrData[PWM_W-1:0];
    end
  end

  // Free-running PWM counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmCnt <= '0;
    else       pwmCnt <= pwmCnt + 1'b1;
  end

  assign pwmOn  = (pwmCnt < levelReg);
  assign effDir = dirReg | {NUM_LINES{forceOutputs}};

  // Per-line source selection: keyed lines may follow their key
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i < LINK_W) begin : g_keyed
      assign srcLvl[i] = linkReg[i] ? keyDetect[i] : hostReg[i];
    end else begin : g_hostOnly
      assign srcLvl[i] = hostReg[i];
    end
  end

  assign activeLvl = srcLvl & {NUM_LINES{pwmOn}};

  // Registered pad drive: polarity 1 = active high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padOut <= '1;
      padOe  <= '0;
    end else begin
      padOut <= ~(activeLvl ^ polReg);
      padOe  <= effDir;
    end
  end

  // Input capture
  gpio_pwm_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (syncIn)
  );

  assign inStatus = syncIn & ~effDir;

  // Read mux
  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_DIR:   rdData[NUM_LINES-1:0] = dirReg;
      SEL_POL:   rdData[NUM_LINES-1:0] = polReg;
      SEL_LINK:  rdData[LINK_W-1:0]    = linkReg;
      SEL_HOST:  rdData[NUM_LINES-1:0] = hostReg;
      SEL_LEVEL: rdData[PWM_W-1:0]     = levelReg;
      SEL_STAT:  rdData[NUM_LINES-1:0] = inStatus;
      default:   rdData = '0;
    endcase
  end

  // Cycles since reset, used to qualify the synchronizer check
  logic [1:0] settleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= '0;
    else if (settleCnt != 2'd3) settleCnt <= settleCnt + 1'b1;
  end

  a_r3_force_all_out: assert property (@(posedge clk) disable iff (!rstN)
    forceOutputs |=> (padOe == {NUM_LINES{1'b1}}));

  a_r3_oe_tracks_dir: assert property (@(posedge clk) disable iff (!rstN)
    !forceOutputs |=> (padOe == $past(dirReg)));

  a_r7_counter_wraps: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pwmCnt == PWM_W'($past(pwmCnt) + 1'b1)));

  a_r7_zero_level_idle: assert property (@(posedge clk) disable iff (!rstN)
    (levelReg == '0) |=> (padOut == ~$past(polReg)));

  a_r9_two_flop_delay: assert property (@(posedge clk) disable iff (!rstN)
    (settleCnt >= 2'd2) |-> (syncIn == $past(padIn, 2)));

endmodule

// File: rtl/gpio_pwm.sv
module gpio_pwm
  import gpio_pwm_pkg::*;
#(
  parameter int NUM_LINES = 7,
  parameter int NUM_KEYS  = 6,
  parameter int PWM_W     = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_KEYS-1:0]  keyDetect,
  input  logic                 forceOutputs,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe
);

  ctrlStrobe_t strobe;

  gpio_pwm_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_pwm_dp #(
    .NUM_LINES (NUM_LINES),
    .NUM_KEYS  (NUM_KEYS),
    .PWM_W     (PWM_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (regWrData),
    .keyDetect    (keyDetect),
    .forceOutputs (forceOutputs),
    .padIn        (padIn),
    .padOut       (padOut),
    .padOe        (padOe),
    .rdData       (regRdData)
  );

endmodule

// File: tb/gpio_pwm_tb.sv
module gpio_pwm_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [5:0] keyDetect = '0;
  logic       forceOutputs = 1'b0;
  logic [6:0] padIn = '0;
  logic [6:0] padOut, padOe;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;
  logic [6:0] polMirror = '0;
  int actCnt [7];

  always #2.5 clk = ~clk;

  gpio_pwm u_dut (
    .clk (clk), .rstN (rstN), .regAddr (regAddr), .regWrEn (regWrEn),
    .regWrData (regWrData), .regRdData (regRdData), .keyDetect (keyDetect),
    .forceOutputs (forceOutputs), .padIn (padIn), .padOut (padOut), .padOe (padOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 3'd1) polMirror = d[6:0];
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Count, per line, cycles where the pad sits at its active level
  task automatic measure();
    for (int l = 0; l < 7; l++) actCnt[l] = 0;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      for (int l = 0; l < 7; l++) if (padOut[l] == polMirror[l]) actCnt[l]++;
    end
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), d);
      check(d == 8'h00, "R1 register reset value", d, 0);
    end
    check(padOe == 7'h00, "R1 output enables after reset", padOe, 0);
    check(padOut == 7'h7F, "R1 pad levels after reset", padOut, 7'h7F);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    regWrite(3'd0, 8'h55); regWrite(3'd1, 8'h2A); regWrite(3'd3, 8'h33);
    regWrite(3'd4, 8'hA7); regWrite(3'd2, 8'h3F);
    regRead(3'd0, d); check(d == 8'h55, "R2 direction readback", d, 8'h55);
    regRead(3'd1, d); check(d == 8'h2A, "R2 polarity readback", d, 8'h2A);
    regRead(3'd3, d); check(d == 8'h33, "R2 host data readback", d, 8'h33);
    regRead(3'd4, d); check(d == 8'hA7, "R2 level readback", d, 8'hA7);
    regRead(3'd2, d); check(d == 8'h3F, "R2 link readback", d, 8'h3F);
    regWrite(3'd2, 8'hFF);
    regRead(3'd2, d); check(d == 8'h3F, "R5 line 6 link bit not stored", d, 8'h3F);
    regWrite(3'd6, 8'hCC); regWrite(3'd7, 8'h11);
    regRead(3'd6, d); check(d == 8'h00, "R2 unused address reads 0", d, 0);
    regRead(3'd0, d); check(d == 8'h55, "R2 direction after unused write", d, 8'h55);
    regRead(3'd4, d); check(d == 8'hA7, "R2 level after unused write", d, 8'hA7);
    regRead(3'd3, d); check(d == 8'h33, "R2 host after unused write", d, 8'h33);
  endtask

  task automatic testOe();
    logic [7:0] d;
    regWrite(3'd0, 8'h2A); waitCycles(2);
    check(padOe == 7'h2A, "R3 enables follow direction", padOe, 7'h2A);
    forceOutputs = 1'b1; waitCycles(2);
    check(padOe == 7'h7F, "R3 force makes all outputs", padOe, 7'h7F);
    regRead(3'd0, d); check(d == 8'h2A, "R3 direction kept under force", d, 8'h2A);
    forceOutputs = 1'b0; waitCycles(2);
    check(padOe == 7'h2A, "R3 enables restored", padOe, 7'h2A);
  endtask

  task automatic testSource();
    regWrite(3'd0, 8'h7F); regWrite(3'd1, 8'h00); regWrite(3'd4, 8'hFF);
    regWrite(3'd3, 8'h7F); regWrite(3'd2, 8'h01);
    keyDetect = 6'h00; waitCycles(2); measure();
    check(actCnt[0] == 0, "R4 linked line follows key 0 (off)", actCnt[0], 0);
    check(actCnt[1] == 255, "R4 unlinked line follows host", actCnt[1], 255);
    keyDetect = 6'h01; waitCycles(2); measure();
    check(actCnt[0] == 255, "R4 linked line follows key 0 (on)", actCnt[0], 255);
    regWrite(3'd2, 8'h00); keyDetect = 6'h00; waitCycles(2); measure();
    check(actCnt[0] == 255, "R4 link cleared uses host bit", actCnt[0], 255);
  endtask

  task automatic testLine6();
    regWrite(3'd2, 8'hFF); regWrite(3'd3, 8'h00); keyDetect = 6'h3F;
    waitCycles(2); measure();
    check(actCnt[5] == 255, "R4 line 5 follows key 5", actCnt[5], 255);
    check(actCnt[6] == 0, "R5 line 6 ignores link and keys", actCnt[6], 0);
    regWrite(3'd3, 8'h40); keyDetect = 6'h00; waitCycles(2); measure();
    check(actCnt[6] == 255, "R5 line 6 follows host bit 6", actCnt[6], 255);
    check(actCnt[2] == 0, "R4 linked line 2 with key off", actCnt[2], 0);
    regWrite(3'd2, 8'h00);
  endtask

  task automatic testPol();
    regWrite(3'd1, 8'h0F); regWrite(3'd3, 8'h7F); waitCycles(2); measure();
    check(actCnt[0] == 255, "R6 active-high line", actCnt[0], 255);
    check(actCnt[6] == 255, "R6 active-low line", actCnt[6], 255);
    @(negedge clk);
    check(padOut[3:0] != 4'h0 || padOut[6:4] != 3'h7, "R6 polarities differ in pad level",
          padOut, 7'h0F);
    regWrite(3'd3, 8'h00); waitCycles(2); measure();
    check(actCnt[0] == 0 && actCnt[6] == 0, "R8 idle source never active",
          actCnt[0] + actCnt[6], 0);
    @(negedge clk);
    check(padOut == 7'h70, "R8 idle lines at inactive level", padOut, 7'h70);
  endtask

  task automatic testPwm();
    int lv [4] = '{0, 1, 64, 200};
    regWrite(3'd1, 8'h00); regWrite(3'd3, 8'h7F); regWrite(3'd2, 8'h00);
    for (int n = 0; n < 4; n++) begin
      regWrite(3'd4, 8'(lv[n])); waitCycles(2); measure();
      check(actCnt[0] == lv[n], "R7 duty over one period", actCnt[0], lv[n]);
    end
    regWrite(3'd4, 8'hFF); waitCycles(2); measure();
    check(actCnt[3] == 255, "R7 full level 255 of 256", actCnt[3], 255);
  endtask

  task automatic testStatus();
    regWrite(3'd0, 8'h00);
    padIn = 7'h00; waitCycles(3);
    regAddr = 3'd5;
    @(negedge clk); padIn = 7'h15;
    @(negedge clk); #1;
    check(regRdData == 8'h00, "R9 not visible after one edge", regRdData, 0);
    @(negedge clk); #1;
    check(regRdData == 8'h15, "R9 visible after two edges", regRdData, 8'h15);
    regWrite(3'd0, 8'h05);
    regAddr = 3'd5; #1;
    check(regRdData == 8'h10, "R9 output lines read 0", regRdData, 8'h10);
    forceOutputs = 1'b1; #1;
    check(regRdData == 8'h00, "R9 forced outputs read 0", regRdData, 0);
    forceOutputs = 1'b0;
  endtask

  task automatic testTiming();
    regWrite(3'd0, 8'h7F); regWrite(3'd1, 8'h01); regWrite(3'd4, 8'hFF);
    regWrite(3'd3, 8'h00); regWrite(3'd2, 8'h01);
    keyDetect = 6'h01; waitCycles(3);
    @(negedge clk); keyDetect = 6'h00;
    @(negedge clk);
    check(padOut[0] == 1'b0, "R10 key release reaches pad after one edge", padOut[0], 0);
  endtask

  initial begin
    waitCycles(4);
    rstN = 1'b1;
    testReset();
    testRegs();
    testOe();
    testSource();
    testLine6();
    testPol();
    testPwm();
    testStatus();
    testTiming();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule